// File: doc/BRIEF.md
# Unaligned Sector Transfer Aligner

This block sits between a byte-addressed DMA channel and a storage port that moves only whole 512-byte sectors. A request carries a byte offset, a byte length and a direction. The block widens the request to whole sectors. It issues the sector commands the storage port needs. It then routes each byte of the sector stream either to or from the DMA side, or to and from a local padding path.

On a read, the block fetches the whole aligned range and drops the leading and trailing padding bytes, so the DMA side receives exactly the requested bytes. On a write, storage bytes outside the request must keep their old contents. So the partial first and last sectors are read back into two local sector buffers first. The block then writes one merged stream: old head bytes, the DMA payload, then old tail bytes. A request aligned at both ends passes straight through.

All data ports are valid/ready streams of one byte per beat, and so is the command port. A beat moves on a rising clock edge where valid and ready are both high. A sender that raises valid keeps valid and its data stable until the beat is taken. Each receiver may hold ready low for any number of cycles. The storage acknowledge and the done pulse are plain single-cycle signals. A request must have a nonzero length, and it is accepted only while `req_ready` is high.

Top module: `sector_aligner`

## Requirements
- R1: After reset, `req_ready` is 1, and `done`, `sto_cmd_valid`, `dma_rd_valid` and `sto_wr_valid` are 0.
- R2: Let head = offset mod 512 and span = head + length. The main storage command has `sto_cmd_lba` = offset >> 9 and `sto_cmd_count` = ceil(span / 512). `sto_cmd_write` = 1 marks a write command and 0 marks a read.
- R3: On a read, exactly `length` bytes reach `dma_rd_data`. They are the storage stream bytes at positions head through head+length−1, in order. The head padding bytes and the tail padding bytes are consumed and discarded.
- R4: On a write with head ≠ 0, a one-sector read of sector offset>>9 is issued first. The first head bytes of the write stream are bytes 0 to head−1 of that sector.
- R5: On a write with tail = span mod 512 ≠ 0, a one-sector read of sector (offset>>9) + (span>>9) is issued. The bytes after the payload are bytes tail to 511 of that sector.
- R6: On a write with both ends unaligned, the head pre-read comes before the tail pre-read. The payload appears exactly once in the write stream, between the head merge bytes and the tail merge bytes. This also holds when both ends fall in the same sector.
- R7: A request with head = 0 and tail = 0 issues one command only, with no pre-read, and the stream carries only payload bytes.
- R8: The sector write command is presented only after every pre-read sector has been fully received: 512 bytes for each pre-read.
- R9: On acceptance, `xfer_remain` loads the length and `xfer_index` loads 0. Each payload byte moved decrements `xfer_remain` by one and increments `xfer_index` by one.
- R10: `done` pulses for one cycle. For a read, it pulses in the cycle after the last storage byte is taken. For a write, it pulses in the cycle after `sto_ack` follows the write stream.
- R11: A presented command and a presented write byte stay valid and unchanged until they are accepted. Stalls on any stream do not change the data delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_offset | input | 32 | Byte offset of the transfer |
| req_len | input | 16 | Byte length, nonzero |
| req_write | input | 1 | 1 = write to storage, 0 = read |
| sto_cmd_valid | output | 1 | Storage command present |
| sto_cmd_ready | input | 1 | Storage takes the command |
| sto_cmd_write | output | 1 | 1 = sector write, 0 = sector read |
| sto_cmd_lba | output | 23 | First sector index |
| sto_cmd_count | output | 9 | Number of sectors |
| sto_rd_valid | input | 1 | Storage read byte present |
| sto_rd_ready | output | 1 | Block takes the storage byte |
| sto_rd_data | input | 8 | Storage read byte |
| sto_wr_valid | output | 1 | Write byte to storage present |
| sto_wr_ready | input | 1 | Storage takes the write byte |
| sto_wr_data | output | 8 | Write byte to storage |
| sto_ack | input | 1 | Storage finished the write command |
| dma_rd_valid | output | 1 | Payload byte for the DMA side present |
| dma_rd_ready | input | 1 | DMA side takes the byte |
| dma_rd_data | output | 8 | Payload byte to the DMA side |
| dma_wr_valid | input | 1 | Payload byte from the DMA side present |
| dma_wr_ready | output | 1 | Block takes the DMA byte |
| dma_wr_data | input | 8 | Payload byte from the DMA side |
| xfer_remain | output | 16 | Payload bytes still to move |
| xfer_index | output | 16 | Payload bytes moved so far |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked by assertions on every cycle:
- a stalled command or write byte holds steady;
- a write command never appears before the pre-reads it needs are complete;
- the two transfer counters always sum to the request length;
- `done` lasts one cycle and arrives with nothing left to move.

Other behaviour only the directed scenarios can show, because it depends on the data and on the command sequence:
- which stream positions are dropped or merged;
- the sector index and count of each command;
- that the payload lands exactly once between the old head bytes and the old tail bytes.

The scenarios cover aligned, head-only, tail-only and double-unaligned writes, including both ends in one sector. They run with and without random stalls.

// File: rtl/sector_aligner_pkg.sv
`timescale 1ns/1ps
package sector_aligner_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PLAN,
    ST_HEAD_CMD,
    ST_HEAD_FILL,
    ST_TAIL_CMD,
    ST_TAIL_FILL,
    ST_MAIN_CMD,
    ST_STREAM,
    ST_WAIT_ACK
  } seq_state_e;

  localparam int unsigned BUF_HEAD = 0;
  localparam int unsigned BUF_TAIL = 1;
  localparam int unsigned NUM_BUFS = 2;

endpackage

// File: rtl/aligner_geom.sv
`timescale 1ns/1ps
module aligner_geom #(
  parameter int unsigned OFF_W     = 32,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned SEC_BYTES = 512,
  localparam int unsigned SEC_W    = $clog2(SEC_BYTES),
  localparam int unsigned LBA_W    = OFF_W - SEC_W,
  localparam int unsigned POS_W    = LEN_W + 2,
  localparam int unsigned CNT_W    = POS_W - SEC_W
) (
  input  logic [OFF_W-1:0] offset,
  input  logic [LEN_W-1:0] length,
  output logic [SEC_W-1:0] head_rem,
  output logic [SEC_W-1:0] tail_rem,
  output logic             head_unal,
  output logic             tail_unal,
  output logic [LBA_W-1:0] first_lba,
  output logic [LBA_W-1:0] last_lba,
  output logic [CNT_W-1:0] sec_count,
  output logic [POS_W-1:0] total_bytes,
  output logic [POS_W-1:0] pay_end
);

  logic [POS_W-1:0] span;

  always_comb begin
    head_rem    = offset[SEC_W-1:0];
    head_unal   = (head_rem != '0);
    span        = POS_W'(head_rem) + POS_W'(length);
    tail_rem    = span[SEC_W-1:0];
    tail_unal   = (tail_rem != '0);
    first_lba   = offset[OFF_W-1:SEC_W];
    last_lba    = first_lba + LBA_W'(span[POS_W-1:SEC_W]);
    sec_count   = span[POS_W-1:SEC_W] + CNT_W'(tail_unal);
    total_bytes = {sec_count, {SEC_W{1'b0}}};
    pay_end     = span;
  end

endmodule

// File: rtl/aligner_sbuf.sv
`timescale 1ns/1ps
module aligner_sbuf #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/aligner_seq.sv
`timescale 1ns/1ps
module aligner_seq
  import sector_aligner_pkg::*;
#(
  parameter int unsigned OFF_W     = 32,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned SEC_BYTES = 512,
  localparam int unsigned SEC_W    = $clog2(SEC_BYTES),
  localparam int unsigned LBA_W    = OFF_W - SEC_W,
  localparam int unsigned POS_W    = LEN_W + 2,
  localparam int unsigned CNT_W    = POS_W - SEC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [OFF_W-1:0] req_offset,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_write,
  output logic [OFF_W-1:0] off_q,
  output logic [LEN_W-1:0] len_q,
  input  logic [SEC_W-1:0] head_rem,
  input  logic             head_unal,
  input  logic             tail_unal,
  input  logic [LBA_W-1:0] first_lba,
  input  logic [LBA_W-1:0] last_lba,
  input  logic [CNT_W-1:0] sec_count,
  input  logic [POS_W-1:0] total_bytes,
  input  logic [POS_W-1:0] pay_end,
  output logic             sto_cmd_valid,
  input  logic             sto_cmd_ready,
  output logic             sto_cmd_write,
  output logic [LBA_W-1:0] sto_cmd_lba,
  output logic [CNT_W-1:0] sto_cmd_count,
  input  logic             sto_rd_valid,
  output logic             sto_rd_ready,
  input  logic [7:0]       sto_rd_data,
  output logic             sto_wr_valid,
  input  logic             sto_wr_ready,
  output logic [7:0]       sto_wr_data,
  input  logic             sto_ack,
  output logic             dma_rd_valid,
  input  logic             dma_rd_ready,
  output logic [7:0]       dma_rd_data,
  input  logic             dma_wr_valid,
  output logic             dma_wr_ready,
  input  logic [7:0]       dma_wr_data,
  output logic [NUM_BUFS-1:0] buf_we,
  output logic [SEC_W-1:0] buf_addr,
  output logic [7:0]       buf_wdata,
  input  logic [NUM_BUFS-1:0][7:0] buf_rdata,
  output logic [LEN_W-1:0] xfer_remain,
  output logic [LEN_W-1:0] xfer_index,
  output logic             done
);

  localparam logic [POS_W-1:0] LAST_IN_SEC = POS_W'(SEC_BYTES - 1);

  seq_state_e       state;
  logic [POS_W-1:0] pos;
  logic             wr_q;
  logic             head_ok;
  logic             tail_ok;

  logic             in_head;
  logic             in_pay;
  logic             fill_beat;
  logic             strm_beat;
  logic             last_pos;
  logic             sec_end;

  // Stream position classification
  always_comb begin
    in_head  = (pos < POS_W'(head_rem));
    in_pay   = !in_head && (pos < pay_end);
    last_pos = (pos == total_bytes - POS_W'(1));
    sec_end  = (pos == LAST_IN_SEC);
  end

  // Command port
  always_comb begin
    sto_cmd_valid = 1'b0;
    sto_cmd_write = 1'b0;
    sto_cmd_lba   = first_lba;
    sto_cmd_count = CNT_W'(1);
    unique case (state)
      ST_HEAD_CMD: sto_cmd_valid = 1'b1;
      ST_TAIL_CMD: begin
        sto_cmd_valid = 1'b1;
        sto_cmd_lba   = last_lba;
      end
      ST_MAIN_CMD: begin
        sto_cmd_valid = 1'b1;
        sto_cmd_write = wr_q;
        sto_cmd_count = sec_count;
      end
      default: ;
    endcase
  end

  // Byte routing between storage, DMA and the sector buffers
  always_comb begin
    sto_rd_ready = 1'b0;
    sto_wr_valid = 1'b0;
    sto_wr_data  = dma_wr_data;
    dma_rd_valid = 1'b0;
    dma_rd_data  = sto_rd_data;
    dma_wr_ready = 1'b0;
    buf_we       = '0;
    buf_addr     = pos[SEC_W-1:0];
    buf_wdata    = sto_rd_data;
    fill_beat    = 1'b0;
    strm_beat    = 1'b0;
    unique case (state)
      ST_HEAD_FILL, ST_TAIL_FILL: begin
        sto_rd_ready = 1'b1;
        fill_beat    = sto_rd_valid;
        buf_we[BUF_HEAD] = sto_rd_valid && (state == ST_HEAD_FILL);
        buf_we[BUF_TAIL] = sto_rd_valid && (state == ST_TAIL_FILL);
      end
      ST_STREAM: begin
        if (wr_q) begin
          if (in_pay) begin
            sto_wr_valid = dma_wr_valid;
            dma_wr_ready = sto_wr_ready;
          end else begin
            sto_wr_valid = 1'b1;
            sto_wr_data  = in_head ? buf_rdata[BUF_HEAD] : buf_rdata[BUF_TAIL];
          end
          strm_beat = sto_wr_valid && sto_wr_ready;
        end else begin
          if (in_pay) begin
            dma_rd_valid = sto_rd_valid;
            sto_rd_ready = dma_rd_ready;
          end else begin
            sto_rd_ready = 1'b1;
          end
          strm_beat = sto_rd_valid && sto_rd_ready;
        end
      end
      default: ;
    endcase
  end

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      pos         <= '0;
      off_q       <= '0;
      len_q       <= '0;
      wr_q        <= 1'b0;
      head_ok     <= 1'b0;
      tail_ok     <= 1'b0;
      xfer_remain <= '0;
      xfer_index  <= '0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            off_q       <= req_offset;
            len_q       <= req_len;
            wr_q        <= req_write;
            xfer_remain <= req_len;
            xfer_index  <= '0;
            head_ok     <= 1'b0;
            tail_ok     <= 1'b0;
            state       <= ST_PLAN;
          end
        end
        ST_PLAN: begin
          pos <= '0;
          if (wr_q && head_unal)      state <= ST_HEAD_CMD;
          else if (wr_q && tail_unal) state <= ST_TAIL_CMD;
          else                        state <= ST_MAIN_CMD;
        end
        ST_HEAD_CMD: if (sto_cmd_ready) state <= ST_HEAD_FILL;
        ST_TAIL_CMD: if (sto_cmd_ready) state <= ST_TAIL_FILL;
        ST_HEAD_FILL: begin
          if (fill_beat) begin
            pos <= pos + POS_W'(1);
            if (sec_end) begin
              pos     <= '0;
              head_ok <= 1'b1;
              state   <= tail_unal ? ST_TAIL_CMD : ST_MAIN_CMD;
            end
          end
        end
        ST_TAIL_FILL: begin
          if (fill_beat) begin
            pos <= pos + POS_W'(1);
            if (sec_end) begin
              pos     <= '0;
              tail_ok <= 1'b1;
              state   <= ST_MAIN_CMD;
            end
          end
        end
        ST_MAIN_CMD: if (sto_cmd_ready) state <= ST_STREAM;
        ST_STREAM: begin
          if (strm_beat) begin
            pos <= pos + POS_W'(1);
            if (in_pay) begin
              xfer_remain <= xfer_remain - LEN_W'(1);
              xfer_index  <= xfer_index + LEN_W'(1);
            end
            if (last_pos) begin
              pos <= '0;
              if (wr_q) begin
                state <= ST_WAIT_ACK;
              end else begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end
            end
          end
        end
        ST_WAIT_ACK: begin
          if (sto_ack) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: a stalled command holds its fields
  p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sto_cmd_valid && !sto_cmd_ready |=> sto_cmd_valid && $stable(sto_cmd_lba)
      && $stable(sto_cmd_count) && $stable(sto_cmd_write));

  // R11: a stalled write byte holds (given a rule-abiding DMA source)
  p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sto_wr_valid && !sto_wr_ready |=> sto_wr_valid && $stable(sto_wr_data));

  // R8: write command only after the required pre-reads finished
  p_write_after_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sto_cmd_valid && sto_cmd_write |-> (!head_unal || head_ok) && (!tail_unal || tail_ok));

  // R9: the two counters always account for the whole request
  p_counter_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, xfer_remain} + {1'b0, xfer_index}) == {1'b0, len_q});

  // R10: done is a single-cycle pulse with nothing left to move
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> xfer_remain == '0);

  // R2: every command asks for at least one sector
  p_cmd_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sto_cmd_valid |-> sto_cmd_count != '0);

endmodule

// File: rtl/sector_aligner.sv
`timescale 1ns/1ps
module sector_aligner
  import sector_aligner_pkg::*;
#(
  parameter int unsigned OFF_W     = 32,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned SEC_BYTES = 512,
  localparam int unsigned SEC_W    = $clog2(SEC_BYTES),
  localparam int unsigned LBA_W    = OFF_W - SEC_W,
  localparam int unsigned POS_W    = LEN_W + 2,
  localparam int unsigned CNT_W    = POS_W - SEC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [OFF_W-1:0] req_offset,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_write,
  output logic             sto_cmd_valid,
  input  logic             sto_cmd_ready,
  output logic             sto_cmd_write,
  output logic [LBA_W-1:0] sto_cmd_lba,
  output logic [CNT_W-1:0] sto_cmd_count,
  input  logic             sto_rd_valid,
  output logic             sto_rd_ready,
  input  logic [7:0]       sto_rd_data,
  output logic             sto_wr_valid,
  input  logic             sto_wr_ready,
  output logic [7:0]       sto_wr_data,
  input  logic             sto_ack,
  output logic             dma_rd_valid,
  input  logic             dma_rd_ready,
  output logic [7:0]       dma_rd_data,
  input  logic             dma_wr_valid,
  output logic             dma_wr_ready,
  input  logic [7:0]       dma_wr_data,
  output logic [LEN_W-1:0] xfer_remain,
  output logic [LEN_W-1:0] xfer_index,
  output logic             done
);

  logic [OFF_W-1:0] off_q;
  logic [LEN_W-1:0] len_q;
  logic [SEC_W-1:0] head_rem;
  logic [SEC_W-1:0] tail_rem;
  logic             head_unal;
  logic             tail_unal;
  logic [LBA_W-1:0] first_lba;
  logic [LBA_W-1:0] last_lba;
  logic [CNT_W-1:0] sec_count;
  logic [POS_W-1:0] total_bytes;
  logic [POS_W-1:0] pay_end;

  logic [NUM_BUFS-1:0]      buf_we;
  logic [SEC_W-1:0]         buf_addr;
  logic [7:0]               buf_wdata;
  logic [NUM_BUFS-1:0][7:0] buf_rdata;

  aligner_geom #(
    .OFF_W(OFF_W), .LEN_W(LEN_W), .SEC_BYTES(SEC_BYTES)
  ) u_geom (
    .offset(off_q), .length(len_q),
    .head_rem(head_rem), .tail_rem(tail_rem),
    .head_unal(head_unal), .tail_unal(tail_unal),
    .first_lba(first_lba), .last_lba(last_lba),
    .sec_count(sec_count), .total_bytes(total_bytes), .pay_end(pay_end)
  );

  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
    aligner_sbuf #(.DEPTH(SEC_BYTES), .W(8)) u_sbuf (
      .clk(clk), .we(buf_we[b]), .waddr(buf_addr), .wdata(buf_wdata),
      .raddr(buf_addr), .rdata(buf_rdata[b])
    );
  end

  aligner_seq #(
    .OFF_W(OFF_W), .LEN_W(LEN_W), .SEC_BYTES(SEC_BYTES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_offset(req_offset), .req_len(req_len), .req_write(req_write),
    .off_q(off_q), .len_q(len_q),
    .head_rem(head_rem), .head_unal(head_unal), .tail_unal(tail_unal),
    .first_lba(first_lba), .last_lba(last_lba), .sec_count(sec_count),
    .total_bytes(total_bytes), .pay_end(pay_end),
    .sto_cmd_valid(sto_cmd_valid), .sto_cmd_ready(sto_cmd_ready),
    .sto_cmd_write(sto_cmd_write), .sto_cmd_lba(sto_cmd_lba),
    .sto_cmd_count(sto_cmd_count),
    .sto_rd_valid(sto_rd_valid), .sto_rd_ready(sto_rd_ready), .sto_rd_data(sto_rd_data),
    .sto_wr_valid(sto_wr_valid), .sto_wr_ready(sto_wr_ready), .sto_wr_data(sto_wr_data),
    .sto_ack(sto_ack),
    .dma_rd_valid(dma_rd_valid), .dma_rd_ready(dma_rd_ready), .dma_rd_data(dma_rd_data),
    .dma_wr_valid(dma_wr_valid), .dma_wr_ready(dma_wr_ready), .dma_wr_data(dma_wr_data),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .xfer_remain(xfer_remain), .xfer_index(xfer_index), .done(done)
  );

  // R5: tail remainder stays consistent with the sector count
  p_tail_geom_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sto_cmd_valid && sto_cmd_write && tail_rem != '0 |-> sec_count != '0);

endmodule

// File: tb/sector_aligner_tb.sv
`timescale 1ns/1ps
module sector_aligner_tb;

  localparam int OFF_W = 32;
  localparam int LEN_W = 16;
  localparam int LBA_W = 23;
  localparam int CNT_W = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [OFF_W-1:0] req_offset = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic             req_write = 1'b0;
  logic             sto_cmd_valid, sto_cmd_write;
  logic             sto_cmd_ready = 1'b0;
  logic [LBA_W-1:0] sto_cmd_lba;
  logic [CNT_W-1:0] sto_cmd_count;
  logic             sto_rd_valid = 1'b0;
  logic             sto_rd_ready;
  logic [7:0]       sto_rd_data = '0;
  logic             sto_wr_valid;
  logic             sto_wr_ready = 1'b0;
  logic [7:0]       sto_wr_data;
  logic             sto_ack = 1'b0;
  logic             dma_rd_valid;
  logic             dma_rd_ready = 1'b0;
  logic [7:0]       dma_rd_data;
  logic             dma_wr_valid = 1'b0;
  logic             dma_wr_ready;
  logic [7:0]       dma_wr_data = '0;
  logic [LEN_W-1:0] xfer_remain, xfer_index;
  logic             done;

  sector_aligner u_dut (.*);

  int vec_cnt = 0;
  int err_cnt = 0;

  // model state
  int c_lba [8];
  int c_cnt [8];
  int c_wr  [8];
  int c_pre [8];
  int ncmd = 0;
  int rd_left = 0, rd_addr = 0, rd_tot = 0;
  int wr_left = 0, wr_addr = 0, wr_bad = 0;
  int ack_timer = 0;
  int rcv_cnt = 0, rcv_bad = 0, src_cnt = 0;
  int cur_off = 0, cur_len = 0;
  int done_cnt = 0;
  bit stall_en = 0;
  bit rd_fired = 0, src_fired = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [7:0] spat(int a);
    logic [31:0] v = a;
    return v[7:0] ^ v[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] dpat(int i);
    logic [31:0] v = i * 7 + 3;
    return v[7:0] ^ 8'hC3;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // storage and DMA models: drive at negedge, sample handshakes 1 ns later
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sto_cmd_ready = (rd_left == 0 && wr_left == 0) && (!stall_en || lfsr[1]);
      if (rd_fired) sto_rd_valid = 1'b0;
      rd_fired = 0;
      if (!sto_rd_valid && rd_left > 0 && (!stall_en || lfsr[2] || lfsr[5])) begin
        sto_rd_valid = 1'b1;
        sto_rd_data  = spat(rd_addr);
      end
      sto_wr_ready = (wr_left > 0) && (!stall_en || lfsr[3] || lfsr[7]);
      sto_ack = (ack_timer == 1);
      if (ack_timer > 0) ack_timer--;
      dma_rd_ready = !stall_en || lfsr[4] || lfsr[9];
      if (src_fired) dma_wr_valid = 1'b0;
      src_fired = 0;
      if (!dma_wr_valid && src_cnt < cur_len && req_write && (!stall_en || lfsr[6] || lfsr[11])) begin
        dma_wr_valid = 1'b1;
        dma_wr_data  = dpat(src_cnt);
      end
      #1;
      if (sto_cmd_valid && sto_cmd_ready) begin
        if (ncmd < 8) begin
          c_lba[ncmd] = int'(sto_cmd_lba);
          c_cnt[ncmd] = int'(sto_cmd_count);
          c_wr[ncmd]  = int'(sto_cmd_write);
          c_pre[ncmd] = rd_tot;
        end
        ncmd++;
        if (sto_cmd_write) begin
          wr_left = int'(sto_cmd_count) * 512;
          wr_addr = int'(sto_cmd_lba) * 512;
        end else begin
          rd_left = int'(sto_cmd_count) * 512;
          rd_addr = int'(sto_cmd_lba) * 512;
        end
      end
      if (sto_rd_valid && sto_rd_ready) begin
        rd_fired = 1; rd_addr++; rd_left--; rd_tot++;
      end
      if (sto_wr_valid && sto_wr_ready) begin
        logic [7:0] e;
        e = (wr_addr >= cur_off && wr_addr < cur_off + cur_len) ? dpat(wr_addr - cur_off) : spat(wr_addr);
        if (sto_wr_data !== e) wr_bad++;
        wr_addr++; wr_left--;
        if (wr_left == 0) ack_timer = 3;
      end
      if (dma_rd_valid && dma_rd_ready) begin
        if (dma_rd_data !== spat(cur_off + rcv_cnt)) rcv_bad++;
        rcv_cnt++;
      end
      if (dma_wr_valid && dma_wr_ready) begin
        src_fired = 1; src_cnt++;
      end
      if (done) done_cnt++;
    end
  end

  task automatic run_req(int off, int len, bit wr, bit stall, string ctag, string dtag);
    int head, span, tail, nsec, lba, tlba, nexp, t;
    int e_lba [3];
    int e_cnt [3];
    int e_wr  [3];
    head = off % 512; span = head + len; tail = span % 512;
    nsec = (span + 511) / 512; lba = off / 512; tlba = lba + span / 512;
    nexp = 0;
    if (wr) begin
      if (head != 0) begin e_lba[nexp] = lba;  e_cnt[nexp] = 1; e_wr[nexp] = 0; nexp++; end
      if (tail != 0) begin e_lba[nexp] = tlba; e_cnt[nexp] = 1; e_wr[nexp] = 0; nexp++; end
      e_lba[nexp] = lba; e_cnt[nexp] = nsec; e_wr[nexp] = 1; nexp++;
    end else begin
      e_lba[0] = lba; e_cnt[0] = nsec; e_wr[0] = 0; nexp = 1;
    end
    @(negedge clk); #2;
    ncmd = 0; rd_tot = 0; wr_bad = 0; rcv_cnt = 0; rcv_bad = 0; src_cnt = 0; done_cnt = 0;
    cur_off = off; cur_len = len; stall_en = stall;
    @(negedge clk);
    req_valid = 1'b1; req_offset = OFF_W'(off); req_len = LEN_W'(len); req_write = wr;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (done_cnt == 0 && t < 40000) begin @(negedge clk); t++; end
    repeat (6) @(negedge clk);
    #2;
    check(ncmd == nexp, ctag, "command count", ncmd, nexp);
    for (int i = 0; i < nexp && i < ncmd; i++) begin
      check(c_lba[i] == e_lba[i], "R2", "command lba", c_lba[i], e_lba[i]);
      check(c_cnt[i] == e_cnt[i] && c_wr[i] == e_wr[i], "R2", "command count/dir",
            c_cnt[i] * 2 + c_wr[i], e_cnt[i] * 2 + e_wr[i]);
    end
    if (wr) begin
      if (ncmd == nexp) check(c_pre[nexp-1] == 512 * (nexp - 1), "R8", "bytes before write cmd",
                              c_pre[nexp-1], 512 * (nexp - 1));
      check(src_cnt == len, dtag, "payload bytes taken", src_cnt, len);
      check(wr_bad == 0 && wr_left == 0, dtag, "write stream mismatches", wr_bad, 0);
    end else begin
      check(rcv_cnt == len, dtag, "bytes delivered", rcv_cnt, len);
      check(rcv_bad == 0, dtag, "read data mismatches", rcv_bad, 0);
    end
    check(xfer_remain == 0 && int'(xfer_index) == len, "R9", "final index", int'(xfer_index), len);
    check(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
    check(req_ready == 1'b1, "R10", "idle after done", int'(req_ready), 1);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
    check(done == 1'b0 && sto_cmd_valid == 1'b0, "R1", "done/cmd", int'(done) + int'(sto_cmd_valid), 0);
    check(dma_rd_valid == 1'b0 && sto_wr_valid == 1'b0, "R1", "stream valids",
          int'(dma_rd_valid) + int'(sto_wr_valid), 0);
    check(xfer_remain == 0 && xfer_index == 0, "R9", "counters at reset", int'(xfer_remain), 0);
  endtask

  task automatic t_mid_counters();
    // R9: counters load at acceptance, before any byte moves
    @(negedge clk);
    cur_off = 4096; cur_len = 100; stall_en = 0; ncmd = 0; done_cnt = 0; rd_tot = 0;
    rcv_cnt = 0; rcv_bad = 0;
    req_valid = 1'b1; req_offset = 32'd4096; req_len = 16'd100; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check(int'(xfer_remain) == 100 && xfer_index == 0, "R9", "loaded remain", int'(xfer_remain), 100);
    while (done_cnt == 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_req(1024, 1024, 0, 0, "R7", "R3");   // aligned read
    run_req(700, 300, 0, 0, "R2", "R3");     // read, both ends in one sector
    run_req(1000, 1500, 0, 0, "R2", "R3");   // read, multi-sector, both unaligned
    run_req(512, 512, 1, 0, "R7", "R7");     // aligned write, pass-through
    run_req(2100, 460, 1, 0, "R4", "R4");    // head only
    run_req(0, 700, 1, 0, "R5", "R5");       // tail only
    run_req(300, 1000, 1, 0, "R6", "R6");    // both ends
    run_req(2570, 20, 1, 0, "R6", "R6");     // both ends in one sector
    t_mid_counters();
    run_req(1000, 1500, 0, 1, "R11", "R11"); // stalled read
    run_req(300, 1000, 1, 1, "R11", "R11");  // stalled write
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    err_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

endmodule